// File: doc/BRIEF.md
# Flash Write-Cycle Qualifier

This block decides whether activity on the three active-low control pins of a flash device (chip enable, write enable, output enable) forms a real bus write that may reach the command register. The pins are synchronised, then filtered against short noise pulses. A write is armed only when the filtered pins show a valid write pattern. It is delivered as a single-clock strobe carrying the address and data present when the cycle ends.

The block also guards the device against writes during supply faults. A digital supply-valid input, when low, suppresses every write. While it is low, the block also drives a command-reset output that returns the command state machine to read mode. The active-low reset models power-on. After power-on, and after every supply dip, a write pattern that is already present is refused. Writes are accepted again only after all three pins have been seen inactive together.

Top module: `flash_write_gate`

## Requirements
- R1: A write cycle arms only while the filtered pins show ce_n=0, we_n=0 and oe_n=1. Any other combination (oe_n low, ce_n high or we_n high) keeps the qualifier idle.
- R2: An armed cycle ends on whichever of ce_n or we_n rises first. At that point wr_stb pulses and wr_addr/wr_data hold the values of addr/data sampled at the end of the cycle.
- R3: If oe_n falls while a cycle is armed, the cycle is abandoned and no strobe is issued.
- R4: A level change on any control pin that lasts fewer than MIN_W clocks, after the SYNC_STAGES synchroniser, is ignored. This holds both for starting a write and for disturbing a write that is already armed.
- R5: While pwr_ok is low, no strobe is issued, an armed cycle is dropped, and cmd_rst is high within SYNC_STAGES+1 clocks. A normal write is accepted again once pwr_ok has returned high.
- R6: A write pattern that is held while pwr_ok is low and then released is never accepted. It is refused until ce_n, we_n and oe_n have all been seen high together.
- R7: A write pattern present when rst_n is released is refused until ce_n, we_n and oe_n have all been seen high together.
- R8: cmd_rst is high during reset and clears once the synchronised pwr_ok is high.
- R9: wr_stb is never high for two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| pwr_ok | input | 1 | Supply above lockout threshold |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | AW | Address bus |
| data | input | DW | Data bus |
| wr_stb | output | 1 | One-clock write-accepted strobe |
| wr_addr | output | AW | Address captured at end of the write |
| wr_data | output | DW | Data captured at end of the write |
| cmd_rst | output | 1 | Forces the command logic to read mode |

## Verification
The embedded properties check, on every clock, the following behaviour:
- arming happens only from the valid pin pattern;
- the strobe is one clock wide;
- lockout silences the strobe and raises cmd_rst;
- an output-enable abort drops the cycle;
- a blocked qualifier stays idle;
- a filter output moves only after its input has differed from it.

Other behaviour depends on sequences that only the bench scenarios create:
- the captured address and data, and which edge ends the cycle;
- rejection of narrow pulses on each pin;
- refusal of writes held across power-on or a supply dip;
- recovery once the pins go idle.

// File: rtl/flash_wq_pkg.sv
package flash_wq_pkg;
   typedef enum logic {
      QS_IDLE  = 1'b0,
      QS_ARMED = 1'b1
   } qstate_t;

   localparam int unsigned CTL_PINS = 3;
   localparam int unsigned PIN_CE   = 0;
   localparam int unsigned PIN_WE   = 1;
   localparam int unsigned PIN_OE   = 2;
endpackage

// File: rtl/fwq_sync.sv
module fwq_sync #(
   parameter int unsigned N      = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("fwq_sync: STAGES must be at least 2");
   end
   if (N < 1) begin : g_bad_width
      $error("fwq_sync: N must be at least 1");
   end

   logic [N-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/fwq_deglitch.sv
module fwq_deglitch #(
   parameter int unsigned MIN_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic q
);
   if (MIN_W < 1) begin : g_bad_minw
      $error("fwq_deglitch: MIN_W must be at least 1");
   end

   if (MIN_W == 1) begin : g_pass
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= din;
      end
   end else begin : g_count
      localparam int unsigned CW  = $clog2(MIN_W + 1);
      localparam logic [CW-1:0] LIM = CW'(MIN_W - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q   <= 1'b0;
            cnt <= '0;
         end else if (din == q) begin
            cnt <= '0;
         end else if (cnt == LIM) begin
            q   <= din;
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // Filter output only moves after its input differed from it.
   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (din == q) |=> $stable(q));
endmodule

// File: rtl/fwq_core.sv
module fwq_core
   import flash_wq_pkg::*;
#(
   parameter int unsigned AW = 16,
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_f,
   input  logic          we_f,
   input  logic          oe_f,
   input  logic          pwr_s,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] data,
   output logic          wr_stb,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   output logic          cmd_rst
);
   qstate_t st;
   logic    blk;
   logic    start_ok, pins_idle, lock;

   assign start_ok  = !ce_f && !we_f && oe_f;
   assign pins_idle = ce_f && we_f && oe_f;
   assign lock      = !pwr_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= QS_IDLE;
         blk     <= 1'b1;
         wr_stb  <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         cmd_rst <= 1'b1;
      end else begin
         wr_stb  <= 1'b0;
         cmd_rst <= lock;
         if (lock) begin
            blk <= 1'b1;
            st  <= QS_IDLE;
         end else begin
            if (pins_idle) blk <= 1'b0;
            unique case (st)
               QS_IDLE: if (start_ok && !blk) st <= QS_ARMED;
               QS_ARMED: begin
                  if (ce_f || we_f) begin
                     wr_stb  <= 1'b1;
                     wr_addr <= addr;
                     wr_data <= data;
                     st      <= QS_IDLE;
                  end else if (!oe_f) begin
                     st <= QS_IDLE;
                  end
               end
               default: st <= QS_IDLE;
            endcase
         end
      end
   end

   assert_arm_cond_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st == QS_ARMED) |-> $past(start_ok));
   assert_oe_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == QS_ARMED && !ce_f && !we_f && !oe_f) |=> (!wr_stb && st == QS_IDLE));
   assert_lock_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> (!wr_stb && cmd_rst));
   assert_blk_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (blk && st == QS_IDLE) |=> (st == QS_IDLE));
   assert_cmdrst_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_s |=> !cmd_rst);
   assert_stb_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);
endmodule

// File: rtl/flash_write_gate.sv
module flash_write_gate
   import flash_wq_pkg::*;
#(
   parameter int unsigned AW          = 16,
   parameter int unsigned DW          = 16,
   parameter int unsigned MIN_W       = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pwr_ok,
   input  logic          ce_n,
   input  logic          we_n,
   input  logic          oe_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] data,
   output logic          wr_stb,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   output logic          cmd_rst
);
   localparam int unsigned SYNC_W = CTL_PINS + 1;

   if (AW < 1 || DW < 1) begin : g_bad_bus
      $error("flash_write_gate: AW and DW must be at least 1");
   end

   logic [SYNC_W-1:0]   raw, synced;
   logic [CTL_PINS-1:0] filt;

   assign raw[PIN_CE]   = ce_n;
   assign raw[PIN_WE]   = we_n;
   assign raw[PIN_OE]   = oe_n;
   assign raw[CTL_PINS] = pwr_ok;

   fwq_sync #(.N(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
   );

   for (genvar p = 0; p < CTL_PINS; p++) begin : g_pin
      fwq_deglitch #(.MIN_W(MIN_W)) u_dg (
         .clk(clk), .rst_n(rst_n), .din(synced[p]), .q(filt[p])
      );
   end

   fwq_core #(.AW(AW), .DW(DW)) u_core (
      .clk(clk), .rst_n(rst_n),
      .ce_f(filt[PIN_CE]), .we_f(filt[PIN_WE]), .oe_f(filt[PIN_OE]),
      .pwr_s(synced[CTL_PINS]),
      .addr(addr), .data(data),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .cmd_rst(cmd_rst)
   );
endmodule

// File: tb/tb_flash_write_gate.sv
module tb_flash_write_gate;
   localparam int AW = 16, DW = 16, MIN_W = 4, SYNC = 2;
   localparam int WIDE   = MIN_W + 4;
   localparam int SETTLE = SYNC + MIN_W + 4;

   logic clk = 1'b0, rst_n = 1'b0, pwr_ok = 1'b1;
   logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] data = '0;
   logic          wr_stb, cmd_rst;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;

   int errors = 0, checks = 0, stb_cnt = 0;
   logic prev_stb = 1'b0;
   logic [AW+DW-1:0] exp_q [$];

   always #4 clk = ~clk;

   flash_write_gate #(.AW(AW), .DW(DW), .MIN_W(MIN_W), .SYNC_STAGES(SYNC)) dut (
      .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok),
      .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .data(data),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .cmd_rst(cmd_rst)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Monitor: pops the scoreboard on every strobe.
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_stb) begin
            stb_cnt++;
            chk(!prev_stb, "R9 strobe wider than one clock", 1, 0);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2 unexpected strobe", {wr_addr, wr_data}, 0);
            end else begin
               logic [AW+DW-1:0] e;
               e = exp_q.pop_front();
               chk({wr_addr, wr_data} == e, "R2 captured addr/data", {wr_addr, wr_data}, e);
            end
         end
         prev_stb = wr_stb;
      end else begin
         prev_stb = 1'b0;
      end
   end

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input bit end_ce, input string req);
      int base;
      base = stb_cnt;
      exp_q.push_back({a, d});
      addr = a; data = d;
      ce_n = 1'b0; tick(2);
      we_n = 1'b0; tick(WIDE);
      if (end_ce) ce_n = 1'b1; else we_n = 1'b1;
      tick(SETTLE);
      ce_n = 1'b1; we_n = 1'b1;
      tick(SETTLE); #1;
      chk(stb_cnt == base + 1, req, stb_cnt - base, 1);
   endtask

   task automatic expect_none(input int base, input string req);
      tick(SETTLE); #1;
      chk(stb_cnt == base, req, stb_cnt - base, 0);
   endtask

   initial begin
      int base;
      tick(1);
      chk(wr_stb == 1'b0, "R8 strobe low in reset", wr_stb, 0);
      chk(cmd_rst == 1'b1, "R8 cmd_rst high in reset", cmd_rst, 1);
      tick(2); rst_n = 1'b1;
      tick(SETTLE + 2);
      chk(cmd_rst == 1'b0, "R8 cmd_rst clears with supply valid", cmd_rst, 0);

      // R1/R2: normal writes, ended by WE and by CE
      do_write(16'h1234, 16'hA5A5, 1'b0, "R2 write ended by we_n");
      do_write(16'h0F0F, 16'h5A5A, 1'b1, "R2 write ended by ce_n");

      // R1: oe_n low throughout, no write
      base = stb_cnt;
      addr = 16'h2222; data = 16'h3333;
      oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0; tick(WIDE);
      we_n = 1'b1; ce_n = 1'b1; tick(SETTLE); oe_n = 1'b1;
      expect_none(base, "R1 oe_n low inhibits write");

      // R3: oe_n falls while armed
      base = stb_cnt;
      ce_n = 1'b0; we_n = 1'b0; tick(WIDE);
      oe_n = 1'b0; tick(WIDE);
      we_n = 1'b1; ce_n = 1'b1; tick(SETTLE); oe_n = 1'b1;
      expect_none(base, "R3 oe_n abort drops cycle");

      // R4: narrow we_n pulse
      base = stb_cnt;
      ce_n = 1'b0; tick(2);
      we_n = 1'b0; tick(MIN_W - 2); we_n = 1'b1;
      tick(SETTLE); ce_n = 1'b1;
      expect_none(base, "R4 narrow we_n pulse rejected");

      // R4: narrow ce_n pulse
      base = stb_cnt;
      we_n = 1'b0; tick(2);
      ce_n = 1'b0; tick(MIN_W - 1); ce_n = 1'b1;
      tick(SETTLE); we_n = 1'b1;
      expect_none(base, "R4 narrow ce_n pulse rejected");

      // R4: narrow oe_n glitch during armed write does not abort
      base = stb_cnt;
      exp_q.push_back({16'hBEEF, 16'hCAFE});
      addr = 16'hBEEF; data = 16'hCAFE;
      ce_n = 1'b0; tick(2); we_n = 1'b0; tick(SETTLE);
      oe_n = 1'b0; tick(2); oe_n = 1'b1; tick(WIDE);
      we_n = 1'b1; tick(SETTLE); ce_n = 1'b1; tick(SETTLE); #1;
      chk(stb_cnt == base + 1, "R4 oe_n glitch ignored", stb_cnt - base, 1);

      // R5: lockout
      pwr_ok = 1'b0; tick(SYNC + 2);
      chk(cmd_rst == 1'b1, "R5 cmd_rst during lockout", cmd_rst, 1);
      base = stb_cnt;
      ce_n = 1'b0; we_n = 1'b0; tick(WIDE);
      we_n = 1'b1; ce_n = 1'b1;
      expect_none(base, "R5 write ignored in lockout");
      pwr_ok = 1'b1; tick(SYNC + 3);
      chk(cmd_rst == 1'b0, "R5 cmd_rst released", cmd_rst, 0);
      tick(SETTLE);
      do_write(16'h4444, 16'h5555, 1'b0, "R5 write after supply return");

      // R6: write held across a supply dip
      base = stb_cnt;
      ce_n = 1'b0; we_n = 1'b0; tick(SETTLE);
      pwr_ok = 1'b0; tick(5);
      pwr_ok = 1'b1; tick(SETTLE);
      we_n = 1'b1; tick(SETTLE); ce_n = 1'b1;
      expect_none(base, "R6 held write refused after dip");
      do_write(16'h6666, 16'h7777, 1'b1, "R6 write after pins idle");

      // R7: write asserted at power-on
      ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
      rst_n = 1'b0; tick(2); rst_n = 1'b1;
      base = stb_cnt;
      tick(2 * SETTLE);
      we_n = 1'b1; tick(SETTLE); ce_n = 1'b1;
      expect_none(base, "R7 write present at power-on refused");
      do_write(16'h8888, 16'h9999, 1'b0, "R7 write after pins idle");

      #1;
      chk(exp_q.size() == 0, "R2 expected strobes missing", exp_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule